// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive side of an I2C target peripheral. It watches an open-drain SCL/SDA pair through synchronizers and glitch filters, and it recognises START and STOP conditions. After each START it collects one frame and compares it with a programmed 7-bit own address, expecting a write direction bit. When the address matches, the block acknowledges and goes on receiving data bytes until the next STOP or repeated START.

Every received byte, the address byte included, is handed to software through a one-entry holding register with a full flag. Software discards the first byte, which is the address, by reading it. If software has not yet read the previous byte when a new byte's eighth bit ends, the block holds SCL low until that read happens. The acknowledge level comes from a software bit. The block takes its value at the eighth falling SCL edge of each frame, so a change made while a frame is stalled applies to the following frame.

Top module: `i2c_slave_rx`

## Requirements
- R1: Both bus inputs pass through a two-flop synchronizer and a filter that changes its output only after three equal consecutive samples. A low pulse of two clock cycles on SCL during a high phase therefore neither adds a bit nor corrupts the received byte.
- R2: SDA falling while SCL is high (START) sends the block to wait for an address from any state, including in the middle of a byte. SDA rising while SCL is high (STOP) returns it to idle, and bits clocked after a STOP without a new START are not acknowledged.
- R3: The first byte after a START is taken MSB first. Bits 7..1 are the address and bit 0 is the direction. The block acknowledges only when the address equals `own_addr` and the direction bit is 0. Otherwise it never drives SDA.
- R4: In the acknowledge clock, SDA is pulled low when the ACK-level bit is 0 and left released (NACK) when it is 1. SDA is driven only while SCL is low on the bus at the moment the drive starts.
- R5: The acknowledge level of a frame is the value of `ack_lvl` at that frame's eighth falling SCL edge. A change made while SCL is being stretched applies to the next frame.
- R6: On a matching address, the address byte `{addr, rw}` is loaded into `rx_data` and `rx_full` rises after the ninth SCL rising edge, not before it. This holds for NACKed frames as well.
- R7: Each data byte of a matched transfer is received MSB first, loaded into `rx_data`, and flags `rx_full` after its ninth SCL rising edge.
- R8: A one-cycle `rd_stb` clears `rx_full`, which reads 0 on the cycle after the strobe. `rx_data` stays unchanged while `rx_full` is 1. After reset `rx_full` is 0 and neither line is driven.
- R9: If `rx_full` is 1 at a frame's eighth falling SCL edge, SCL is held low until the register is read. It is then released with the acknowledge level already placed on SDA, and the new byte is loaded afterwards.
- R10: With `en` low the block drives neither line, does not acknowledge and does not load the register.
- R11: After a non-matching address, the following data bytes are neither acknowledged nor loaded until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| ack_lvl | input | 1 | Acknowledge level: 0 = ACK (drive low), 1 = NACK |
| own_addr | input | 7 | Own 7-bit target address |
| rd_stb | input | 1 | One-cycle read strobe for the receive register |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Receive register holds an unread byte |

## Verification
The assertions assume a well-behaved controller. SDA changes only while SCL is low, except for START and STOP. Each SCL phase lasts longer than the filter delay of about six clocks, so the block's own drive of SDA always begins while the bus SCL is low. They also assume that the holding register is only ever loaded while empty, since the stretch prevents a load over an unread byte. The bench stays within these limits by using ten-cycle half periods. It changes SDA only in the middle of a low phase, waits for SCL to read high after releasing it, and injects glitches only as two-cycle SCL pulses well inside a high phase.

// File: rtl/i2c_slave_rx_pkg.sv
package i2c_slave_rx_pkg;

  // Frame engine states
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for a START
    ST_ADDR = 3'd1,  // shifting the address byte
    ST_DATA = 3'd2,  // shifting a data byte
    ST_ACK  = 3'd3,  // acknowledge clock (possibly stretched)
    ST_SKIP = 3'd4   // not addressed: wait for next START
  } srx_state_e;

  // Idle level of both bus lines
  localparam logic BUS_IDLE = 1'b1;

endpackage

// File: rtl/srx_line_filter.sv
module srx_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  import i2c_slave_rx_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= {SYNC_STAGES{BUS_IDLE}};
      hist_q  <= {FILT_LEN{BUS_IDLE}};
      level_q <= BUS_IDLE;
      prev_q  <= BUS_IDLE;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        level_q <= 1'b1;
      else if (~|hist_q)
        level_q <= 1'b0;
      prev_q <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~prev_q;
  assign fall_o  = ~level_q & prev_q;

endmodule

// File: rtl/srx_rx_hold.sv
module srx_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              full_o
);

  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (load_i) begin
      data_q <= din_i;
      full_q <= 1'b1;
    end else if (rd_stb_i) begin
      full_q <= 1'b0;
    end
  end

  assign dout_o = data_q;
  assign full_o = full_q;

endmodule

// File: rtl/srx_frame_engine.sv
module srx_frame_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              ack_lvl,
  input  logic              rx_full,
  output logic [DATA_W-1:0] shift_o,
  output logic              load_o,
  output logic              sda_dl_o,
  output logic              scl_dl_o
);
  import i2c_slave_rx_pkg::*;

  localparam int              CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  srx_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shift_q;
  logic              sda_dl_q;
  logic              scl_dl_q;
  logic              ack_q;
  logic              armed_q;
  logic              load_q;

  logic start_c;
  logic stop_c;
  logic addr_hit;

  assign start_c  = scl_lvl & sda_fall;
  assign stop_c   = scl_lvl & sda_rise;
  assign addr_hit = (shift_q[DATA_W-1:1] == own_addr) && !shift_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shift_q  <= '0;
      sda_dl_q <= 1'b0;
      scl_dl_q <= 1'b0;
      ack_q    <= 1'b0;
      armed_q  <= 1'b0;
      load_q   <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (!en) begin
        state_q  <= ST_IDLE;
        sda_dl_q <= 1'b0;
        scl_dl_q <= 1'b0;
        armed_q  <= 1'b0;
      end else if (start_c) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_dl_q <= 1'b0;
        scl_dl_q <= 1'b0;
        armed_q  <= 1'b0;
      end else if (stop_c) begin
        state_q  <= ST_IDLE;
        sda_dl_q <= 1'b0;
        scl_dl_q <= 1'b0;
        armed_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && cnt_q != LAST_BIT) begin
              shift_q <= {shift_q[DATA_W-2:0], sda_lvl};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST_BIT) begin
              if (state_q == ST_ADDR && !addr_hit) begin
                state_q <= ST_SKIP;
              end else begin
                // eighth falling edge: latch ack level, maybe stretch
                state_q  <= ST_ACK;
                ack_q    <= ack_lvl;
                scl_dl_q <= rx_full;
                armed_q  <= !rx_full;
                sda_dl_q <= !rx_full && !ack_lvl;
              end
            end
          end
          ST_ACK: begin
            if (!armed_q) begin
              // stretched: place ack on SDA once the register is empty
              if (!rx_full) begin
                armed_q  <= 1'b1;
                sda_dl_q <= !ack_q;
              end
            end else begin
              scl_dl_q <= 1'b0;
              if (scl_rise)
                load_q <= 1'b1;
              if (scl_fall) begin
                sda_dl_q <= 1'b0;
                armed_q  <= 1'b0;
                state_q  <= ST_DATA;
                cnt_q    <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign shift_o  = shift_q;
  assign load_o   = load_q;
  assign sda_dl_o = sda_dl_q;
  assign scl_dl_o = scl_dl_q;

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ack_lvl,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              rd_stb,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full
);

  localparam int N_LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [N_LINES-1:0] pin_raw;
  logic [N_LINES-1:0] lvl;
  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] fall;
  logic [DATA_W-1:0]  shift_w;
  logic               load_w;
  logic               full_w;

  assign pin_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    srx_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_raw[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  srx_frame_engine #(.DATA_W(DATA_W)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .scl_lvl (lvl[0]),
    .scl_rise(rise[0]),
    .scl_fall(fall[0]),
    .sda_lvl (lvl[1]),
    .sda_rise(rise[1]),
    .sda_fall(fall[1]),
    .own_addr(own_addr),
    .ack_lvl (ack_lvl),
    .rx_full (full_w),
    .shift_o (shift_w),
    .load_o  (load_w),
    .sda_dl_o(sda_drive_low),
    .scl_dl_o(scl_drive_low)
  );

  srx_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_w),
    .din_i   (shift_w),
    .rd_stb_i(rd_stb),
    .dout_o  (rx_data),
    .full_o  (full_w)
  );

  assign rx_full = full_w;

endmodule

// File: rtl/i2c_slave_rx_checker.sv
module i2c_slave_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              rd_stb,
  input logic              scl_i,
  input logic              scl_drive_low,
  input logic              sda_drive_low,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full
);

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    rx_full && !rd_stb |=> rx_full && $stable(rx_data));  // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_stb && rx_full |=> !rx_full);  // R8

  AST_STRETCH_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> $past(rx_full));  // R9

  AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    scl_drive_low && !rx_full && $past(!rx_full) |=> !scl_drive_low);  // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_drive_low && !scl_drive_low);  // R10

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !scl_i);  // R4

endmodule

bind i2c_slave_rx i2c_slave_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en           (en),
  .rd_stb       (rd_stb),
  .scl_i        (scl_i),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low),
  .rx_data      (rx_data),
  .rx_full      (rx_full)
);

// File: tb/i2c_slave_rx_tb.sv
`timescale 1ns/1ps
module i2c_slave_rx_tb;

  localparam int H   = 10;        // half SCL period in clocks
  localparam int WD  = 190000;
  localparam logic [6:0] OWN = 7'h2C;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       ack_lvl = 1'b0;
  logic       rd_stb = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       g_scl = 1'b0;
  logic       scl_bus;
  logic       sda_bus;
  logic       scl_drive_low;
  logic       sda_drive_low;
  logic [7:0] rx_data;
  logic       rx_full;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_bus = m_scl & ~g_scl & ~scl_drive_low;
  assign sda_bus = m_sda & ~sda_drive_low;

  i2c_slave_rx u_dut (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .ack_lvl      (ack_lvl),
    .own_addr     (OWN),
    .rd_stb       (rd_stb),
    .scl_i        (scl_bus),
    .sda_i        (sda_bus),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .rx_data      (rx_data),
    .rx_full      (rx_full)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_bus) tick(1);
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(H/2);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H/2);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(H/2);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic m_bit(input logic b, input bit glitch);
    m_sda = b; tick(H/2);
    m_scl = 1'b1; wait_high();
    if (glitch) begin
      tick(3); g_scl = 1'b1; tick(2); g_scl = 1'b0; tick(H-5);
    end else begin
      tick(H);
    end
    m_scl = 1'b0; tick(H/2);
  endtask

  task automatic m_byte(input logic [7:0] b, input bit glitch,
                        output logic ack, output logic full_pre);
    for (int i = 7; i >= 0; i--) m_bit(b[i], glitch);
    m_sda = 1'b1; tick(H/2);
    m_scl = 1'b1; wait_high();
    full_pre = rx_full;
    tick(H/2);
    ack = sda_bus;
    tick(H/2);
    m_scl = 1'b0; tick(H/2);
  endtask

  task automatic rd(output logic [7:0] d);
    d = rx_data;
    rd_stb = 1'b1; tick(1);
    rd_stb = 1'b0; tick(1);
  endtask

  logic       ack, fp;
  logic [7:0] d;

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(5);
    // R8: reset state
    chk("R8 reset full", rx_full, 0);
    chk("R8 reset sda", sda_drive_low, 0);
    chk("R8 reset scl", scl_drive_low, 0);

    // R3/R6: sweep every address and direction
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic hit;
        hit = (a == OWN) && (rw == 0);
        m_start();
        m_byte({a[6:0], rw[0]}, 0, ack, fp);
        chk("R3 ack", ack, !hit);
        chk("R6 full", rx_full, hit);
        if (hit) begin
          chk("R6 not before ninth rise", fp, 0);
          rd(d);
          chk("R6 addr byte", d, {a[6:0], 1'b0});
          chk("R8 cleared", rx_full, 0);
        end
        m_stop();
        chk("R3 sda released", sda_drive_low, 0);
      end
    end

    // R1: glitches on SCL high phases
    m_start();
    m_byte({OWN, 1'b0}, 1, ack, fp);
    chk("R1 addr ack", ack, 0);
    rd(d);
    chk("R1 addr byte", d, {OWN, 1'b0});
    m_byte(8'h96, 1, ack, fp);
    chk("R1 data ack", ack, 0);
    rd(d);
    chk("R1 data byte", d, 8'h96);
    m_stop();

    // R7: all data values in one transfer
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    rd(d);
    for (int v = 0; v < 256; v++) begin
      m_byte(v[7:0], 0, ack, fp);
      chk("R7 ack", ack, 0);
      chk("R7 full", rx_full, 1);
      rd(d);
      chk("R7 data", d, v[7:0]);
    end
    m_stop();

    // R4: NACK level
    ack_lvl = 1'b1;
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    chk("R4 nack", ack, 1);
    chk("R4 full on nack", rx_full, 1);
    rd(d);
    ack_lvl = 1'b0;
    m_stop();

    // R9/R5: stretch while previous byte unread
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    chk("R9 addr unread", rx_full, 1);
    fork
      m_byte(8'hC3, 0, ack, fp);
      begin
        tick(200);
        chk("R9 stretch held", scl_drive_low, 1);
        chk("R9 scl low", scl_bus, 0);
        ack_lvl = 1'b1;
        tick(40);
        chk("R9 still held", scl_drive_low, 1);
        rd(d);
        chk("R9 pending byte", d, {OWN, 1'b0});
      end
    join
    chk("R5 old level kept", ack, 0);
    chk("R9 new byte full", rx_full, 1);
    rd(d);
    chk("R9 new byte", d, 8'hC3);
    m_byte(8'h3C, 0, ack, fp);
    chk("R5 new level next frame", ack, 1);
    rd(d);
    chk("R5 data", d, 8'h3C);
    ack_lvl = 1'b0;
    m_stop();

    // R11: mismatch then data
    m_start();
    m_byte({OWN ^ 7'h01, 1'b0}, 0, ack, fp);
    chk("R11 addr nack", ack, 1);
    m_byte(8'h5A, 0, ack, fp);
    chk("R11 data nack", ack, 1);
    chk("R11 not loaded", rx_full, 0);
    m_stop();

    // R2: repeated start mid byte, then bits after stop
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    rd(d);
    for (int i = 0; i < 4; i++) m_bit(1'b0, 0);
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    chk("R2 restart ack", ack, 0);
    chk("R2 restart full", rx_full, 1);
    rd(d);
    chk("R2 restart addr", d, {OWN, 1'b0});
    m_stop();
    m_scl = 1'b0; tick(H/2);
    m_byte({OWN, 1'b0}, 0, ack, fp);
    chk("R2 after stop nack", ack, 1);
    chk("R2 after stop empty", rx_full, 0);
    m_stop();

    // R10: disabled
    en = 1'b0;
    tick(2);
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    chk("R10 no ack", ack, 1);
    chk("R10 no load", rx_full, 0);
    chk("R10 no stretch", scl_drive_low, 0);
    m_stop();
    en = 1'b1;
    tick(2);
    m_start();
    m_byte({OWN, 1'b0}, 0, ack, fp);
    chk("R10 re-enabled ack", ack, 0);
    rd(d);
    m_stop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule